// File: doc/BRIEF.md
# Two-Point Operating-Point Sequencer

This block moves a processor core between two operating points when thermal throttling is requested. The normal point is the full frequency ratio at the normal voltage code. The low point is the minimum frequency ratio at a lower voltage code. The only trigger is the thermal control circuit's active signal, qualified by an enable bit. No other request source reaches the block.

On the way down, the ratio switches first. While the clock generator relocks, bus traffic is held off, and edge interrupts that arrive are latched. They are released once the relock completes. The voltage code then walks down one table entry (12.5 mV) at a time. Each entry is held for a settle time before the next one is issued. Execution and bus service continue during the walk.

The return to the normal point needs two things: a cooled indication, and a minimum activation time counted from the cycle the low frequency was engaged. The return runs in the opposite order. The voltage code walks back up entry by entry, and only then is the full ratio restored behind a second relock. If the thermal signal comes back during the voltage climb, the block turns around at the current code and walks down again. The clock generator, regulator and interrupt controller lie outside the block.

Top module: `oppSequencer`

## Requirements
- R1: During and straight after reset, `ratioLow` is 0, `vidCode` equals VID_NORM, and `busBlock`, `irqHeld` and `irqOut` are 0.
- R2: In the normal point with `enable`=1, a sampled `tccActive`=1 sets `ratioLow`=1 and `busBlock`=1 from the next cycle. `vidCode` stays at VID_NORM while blocked. `busBlock` drops in the cycle after `lockDone` is sampled high.
- R3: An `edgeIrq` pulse sampled while `busBlock`=1 sets `irqHeld`=1 and keeps `irqOut` at 0. The held interrupt leaves as a one-cycle `irqOut`=1 pulse, one cycle after `busBlock` falls, and `irqHeld` clears in that same cycle. This also applies to a pulse sampled in the same cycle as `lockDone`. An `edgeIrq` pulse sampled while not blocked gives a one-cycle `irqOut` pulse in the next cycle.
- R4: One cycle after the relock, `vidCode` drops by exactly one. Each further drop of one follows SETTLE cycles later, until VID_LOW is reached. `busBlock` stays 0 and `ratioLow` stays 1 throughout the walk.
- R5: No upward voltage step occurs until both conditions hold: `cooled` has been sampled high, and MIN_ACT cycles have elapsed since the relock edge. Once the later of the two is met, the first up-step (`vidCode` = VID_LOW+1) follows two cycles after the edge where it is sampled.
- R6: On return, `vidCode` rises by one every SETTLE cycles. `ratioLow` stays 1 until VID_NORM has been held for SETTLE cycles. In the next cycle, `ratioLow`=0 and `busBlock`=1. After `lockDone`, the block is back at the normal point with `busBlock`=0.
- R7: A `tccActive`=1 (with `enable`=1) sampled during the voltage climb reverses direction at the current code. No frequency switch occurs, and the next step is one entry down, issued when the running settle time expires.
- R8: With `enable`=0, `tccActive` has no effect: `ratioLow`, `busBlock` and `vidCode` stay at their normal-point values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tccActive | input | 1 | Thermal control circuit active |
| enable | input | 1 | Allows the low-point mechanism to engage |
| cooled | input | 1 | The part has cooled below the trip point |
| lockDone | input | 1 | The clock generator has settled on the new ratio |
| edgeIrq | input | 1 | Edge-interrupt event, one cycle per event |
| ratioLow | output | 1 | 1 selects the minimum frequency ratio |
| vidCode | output | VID_W | Voltage code sent to the regulator |
| busBlock | output | 1 | Bus traffic held off during a ratio switch |
| irqHeld | output | 1 | An edge interrupt is latched and pending |
| irqOut | output | 1 | Edge interrupt delivered to the core |

## Verification
Two functions can fall in the same cycle: the end of a ratio switch and the arrival of an edge interrupt. One vector raises `edgeIrq` in the very cycle that `lockDone` is sampled. The bench then expects the event to be latched, because bus blocking is still in force at that edge. It also expects the event to leave as a single `irqOut` pulse one cycle after `busBlock` falls, with nothing lost and nothing doubled. A second overlap exists between a climbing voltage step and a returning thermal request. It is provoked mid-settle, and the bench checks that the next code is one entry lower, with the frequency untouched.

// File: rtl/oppSeqPkg.sv
package oppSeqPkg;

  typedef enum logic [2:0] {
    ST_NORMAL,
    ST_FREQ_DOWN,
    ST_VOLT_DOWN,
    ST_LOW,
    ST_VOLT_UP,
    ST_FREQ_UP
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic startTimer;
  } seqStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic atLow;
    logic atNorm;
    logic settled;
    logic minDone;
  } seqStatus_t;

endpackage

// File: rtl/oppSeqCtrl.sv
module oppSeqCtrl
  import oppSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tccActive,
  input  logic       enable,
  input  logic       cooled,
  input  logic       lockDone,
  input  seqStatus_t stat,
  output seqStrobe_t stb,
  output logic       ratioLow,
  output logic       busBlock
);

  seqState_t state, nxt;
  logic      tccReq;

  assign tccReq = enable && tccActive;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_NORMAL;
    else       state <= nxt;
  end

  always_comb begin
    nxt = state;
    stb = '0;
    case (state)
      ST_NORMAL:    if (tccReq) nxt = ST_FREQ_DOWN;
      ST_FREQ_DOWN: if (lockDone) begin
                      nxt = ST_VOLT_DOWN;
                      stb.startTimer = 1'b1;
                    end
      ST_VOLT_DOWN: if (stat.settled) begin
                      if (stat.atLow) nxt = ST_LOW;
                      else            stb.stepDown = 1'b1;
                    end
      ST_LOW:       if (cooled && stat.minDone) nxt = ST_VOLT_UP;
      ST_VOLT_UP:   if (tccReq) nxt = ST_VOLT_DOWN;
                    else if (stat.settled) begin
                      if (stat.atNorm) nxt = ST_FREQ_UP;
                      else             stb.stepUp = 1'b1;
                    end
      ST_FREQ_UP:   if (lockDone) nxt = ST_NORMAL;
      default:      nxt = ST_NORMAL;
    endcase
  end

  assign ratioLow = (state == ST_FREQ_DOWN) || (state == ST_VOLT_DOWN) ||
                    (state == ST_LOW) || (state == ST_VOLT_UP);
  assign busBlock = (state == ST_FREQ_DOWN) || (state == ST_FREQ_UP);

  // R2
  block_at_norm_chk: assert property (@(posedge clk) disable iff (!rstN)
    busBlock |-> stat.atNorm);

  // R6
  ratio_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ratioLow) |-> stat.atNorm);

  // R8
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NORMAL && !enable) |=> !busBlock && !ratioLow);

endmodule

// File: rtl/oppSeqData.sv
module oppSeqData
  import oppSeqPkg::*;
#(
  parameter int VID_W    = 6,
  parameter int VID_NORM = 40,
  parameter int VID_LOW  = 32,
  parameter int SETTLE   = 4,
  parameter int MIN_ACT  = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       stb,
  input  logic             busBlock,
  input  logic             edgeIrq,
  output seqStatus_t       stat,
  output logic [VID_W-1:0] vidCode,
  output logic             irqHeld,
  output logic             irqOut
);

  localparam int SET_W = (SETTLE > 1) ? $clog2(SETTLE + 1) : 1;
  localparam int TMR_W = $clog2(MIN_ACT + 1);
  localparam logic [VID_W-1:0] NORM_CODE = VID_W'(VID_NORM);
  localparam logic [VID_W-1:0] LOW_CODE  = VID_W'(VID_LOW);
  localparam logic [SET_W-1:0] SET_LOAD  = SET_W'(SETTLE - 1);
  localparam logic [TMR_W-1:0] TMR_END   = TMR_W'(MIN_ACT);

  logic [VID_W-1:0] vidQ;
  logic [SET_W-1:0] settleQ;
  logic [TMR_W-1:0] timerQ;
  logic             heldQ, outQ;
  logic             anyStep;

  assign anyStep = stb.stepUp || stb.stepDown;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vidQ    <= NORM_CODE;
      settleQ <= '0;
    end else begin
      if (stb.stepUp)        vidQ <= vidQ + VID_W'(1);
      else if (stb.stepDown) vidQ <= vidQ - VID_W'(1);
      if (anyStep)           settleQ <= SET_LOAD;
      else if (settleQ != '0) settleQ <= settleQ - SET_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  timerQ <= '0;
    else if (stb.startTimer)    timerQ <= '0;
    else if (timerQ != TMR_END) timerQ <= timerQ + TMR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldQ <= 1'b0;
      outQ  <= 1'b0;
    end else if (busBlock) begin
      heldQ <= heldQ || edgeIrq;
      outQ  <= 1'b0;
    end else begin
      heldQ <= 1'b0;
      outQ  <= heldQ || edgeIrq;
    end
  end

  assign stat.atLow   = (vidQ == LOW_CODE);
  assign stat.atNorm  = (vidQ == NORM_CODE);
  assign stat.settled = (settleQ == '0);
  assign stat.minDone = (timerQ == TMR_END);
  assign vidCode      = vidQ;
  assign irqHeld      = heldQ;
  assign irqOut       = outQ;

  // R4
  single_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vidQ != $past(vidQ)) |-> (vidQ == $past(vidQ) + VID_W'(1)) ||
                              (vidQ == $past(vidQ) - VID_W'(1)));

  // R4
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyStep |-> (settleQ == '0));

  // R5
  min_time_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepUp |-> stat.minDone);

  // R3
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busBlock && $past(busBlock)) |-> !irqOut);

  // R4
  vid_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vidQ <= NORM_CODE) && (vidQ >= LOW_CODE));

endmodule

// File: rtl/oppSequencer.sv
module oppSequencer
  import oppSeqPkg::*;
#(
  parameter int VID_W    = 6,
  parameter int VID_NORM = 40,
  parameter int VID_LOW  = 32,
  parameter int SETTLE   = 4,
  parameter int MIN_ACT  = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tccActive,
  input  logic             enable,
  input  logic             cooled,
  input  logic             lockDone,
  input  logic             edgeIrq,
  output logic             ratioLow,
  output logic [VID_W-1:0] vidCode,
  output logic             busBlock,
  output logic             irqHeld,
  output logic             irqOut
);

  seqStrobe_t stb;
  seqStatus_t stat;

  oppSeqCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .tccActive (tccActive),
    .enable    (enable),
    .cooled    (cooled),
    .lockDone  (lockDone),
    .stat      (stat),
    .stb       (stb),
    .ratioLow  (ratioLow),
    .busBlock  (busBlock)
  );

  oppSeqData #(
    .VID_W    (VID_W),
    .VID_NORM (VID_NORM),
    .VID_LOW  (VID_LOW),
    .SETTLE   (SETTLE),
    .MIN_ACT  (MIN_ACT)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busBlock (busBlock),
    .edgeIrq  (edgeIrq),
    .stat     (stat),
    .vidCode  (vidCode),
    .irqHeld  (irqHeld),
    .irqOut   (irqOut)
  );

endmodule

// File: tb/oppSequencer_test.sv
`timescale 1ns/1ps
module oppSequencer_test;

  localparam int NORM = 40;
  localparam int LOW  = 32;
  localparam int S    = 4;
  localparam int MA   = 48;
  localparam int D    = NORM - LOW;

  typedef struct packed {
    logic [7:0] lockLat;
    logic [1:0] irqMode;   // 0 none, 1 during block, 2 with lockDone
    logic [7:0] coolAt;    // 0: cooled at once
    logic       rev;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{8'd1, 2'd0, 8'd0,  1'b0},
    '{8'd3, 2'd1, 8'd0,  1'b0},
    '{8'd2, 2'd2, 8'd60, 1'b0},
    '{8'd5, 2'd1, 8'd0,  1'b1}
  };

  logic clk = 1'b0;
  logic rstN, tccActive, enable, cooled, lockDone, edgeIrq;
  logic ratioLow, busBlock, irqHeld, irqOut;
  logic [5:0] vidCode;

  int checks = 0;
  int fails  = 0;
  int t;

  always #2.5 clk = ~clk;

  oppSequencer #(.VID_W(6), .VID_NORM(NORM), .VID_LOW(LOW),
                 .SETTLE(S), .MIN_ACT(MA)) uut (
    .clk(clk), .rstN(rstN), .tccActive(tccActive), .enable(enable),
    .cooled(cooled), .lockDone(lockDone), .edgeIrq(edgeIrq),
    .ratioLow(ratioLow), .vidCode(vidCode), .busBlock(busBlock),
    .irqHeld(irqHeld), .irqOut(irqOut)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic adv(input int n);
    while (t < n) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic runVec(input vec_t v);
    int eu;
    int cAt;
    cAt = int'(v.coolAt);
    eu  = (cAt + 1 > MA + 1) ? cAt + 1 : MA + 1;
    tccActive = 1'b1; cooled = 1'b0; enable = 1'b1;
    @(negedge clk);
    chk("R2", "ratioLow on entry", int'(ratioLow), 1);
    chk("R2", "busBlock on entry", int'(busBlock), 1);
    chk("R2", "vid on entry", int'(vidCode), NORM);
    if (v.irqMode == 2'd1) edgeIrq = 1'b1;
    for (int i = 0; i < int'(v.lockLat); i++) begin
      @(negedge clk);
      edgeIrq = 1'b0;
      chk("R2", "busBlock while relock", int'(busBlock), 1);
      chk("R2", "vid while relock", int'(vidCode), NORM);
      chk("R3", "irqOut while blocked", int'(irqOut), 0);
    end
    lockDone = 1'b1;
    if (v.irqMode == 2'd2) edgeIrq = 1'b1;
    @(negedge clk);
    t = 0;
    lockDone = 1'b0; edgeIrq = 1'b0; tccActive = 1'b0;
    if (cAt == 0) cooled = 1'b1;
    chk("R2", "busBlock after lock", int'(busBlock), 0);
    chk("R3", "irqHeld after lock", int'(irqHeld), int'(v.irqMode != 2'd0));
    chk("R3", "irqOut after lock", int'(irqOut), 0);
    adv(1);
    chk("R4", "first down step", int'(vidCode), NORM - 1);
    chk("R3", "irq release pulse", int'(irqOut), int'(v.irqMode != 2'd0));
    chk("R3", "irqHeld cleared", int'(irqHeld), 0);
    adv(2);
    chk("R3", "irq pulse one cycle", int'(irqOut), 0);
    adv(S);
    chk("R4", "settle hold", int'(vidCode), NORM - 1);
    adv(S + 1);
    chk("R4", "second down step", int'(vidCode), NORM - 2);
    adv(1 + S * (D - 1));
    chk("R4", "low code reached", int'(vidCode), LOW);
    chk("R4", "bus free while stepping", int'(busBlock), 0);
    chk("R4", "ratio low while stepping", int'(ratioLow), 1);
    if (cAt != 0) begin
      adv(cAt);
      cooled = 1'b1;
    end
    adv(eu);
    chk("R5", "no early up step", int'(vidCode), LOW);
    adv(eu + 1);
    chk("R5", "first up step", int'(vidCode), LOW + 1);
    if (!v.rev) begin
      adv(eu + S * D);
      chk("R6", "norm code before ratio", int'(vidCode), NORM);
      chk("R6", "ratio held low", int'(ratioLow), 1);
      chk("R6", "bus free before switch", int'(busBlock), 0);
      adv(eu + S * D + 1);
      chk("R6", "ratio restored", int'(ratioLow), 0);
      chk("R6", "bus blocked on restore", int'(busBlock), 1);
    end else begin
      adv(eu + 1 + 2 * S);
      chk("R7", "climb before reversal", int'(vidCode), LOW + 3);
      adv(eu + 2 * S + 2);
      tccActive = 1'b1;
      adv(eu + 3 * S);
      tccActive = 1'b0;
      chk("R7", "code kept at reversal", int'(vidCode), LOW + 3);
      chk("R7", "no freq switch", int'(ratioLow), 1);
      chk("R7", "bus free at reversal", int'(busBlock), 0);
      adv(eu + 3 * S + 1);
      chk("R7", "step down after reversal", int'(vidCode), LOW + 2);
      for (int k = 0; k < 600 && !busBlock; k++) @(negedge clk);
      chk("R6", "norm code at restore", int'(vidCode), NORM);
      chk("R6", "ratio at restore", int'(ratioLow), 0);
    end
    lockDone = 1'b1;
    @(negedge clk);
    lockDone = 1'b0; cooled = 1'b0;
    chk("R6", "bus free at normal", int'(busBlock), 0);
    chk("R6", "ratio normal", int'(ratioLow), 0);
    chk("R6", "vid normal", int'(vidCode), NORM);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; tccActive = 1'b0; enable = 1'b0; cooled = 1'b0;
    lockDone = 1'b0; edgeIrq = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "ratioLow in reset", int'(ratioLow), 0);
    chk("R1", "vid in reset", int'(vidCode), NORM);
    chk("R1", "busBlock in reset", int'(busBlock), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "irqHeld after reset", int'(irqHeld), 0);
    chk("R1", "irqOut after reset", int'(irqOut), 0);
    chk("R1", "vid after reset", int'(vidCode), NORM);

    foreach (VECS[i]) runVec(VECS[i]);

    enable = 1'b0; tccActive = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R8", "ratio with enable off", int'(ratioLow), 0);
      chk("R8", "bus with enable off", int'(busBlock), 0);
      chk("R8", "vid with enable off", int'(vidCode), NORM);
    end
    tccActive = 1'b0; enable = 1'b1;

    @(negedge clk);
    edgeIrq = 1'b1;
    @(negedge clk);
    edgeIrq = 1'b0;
    chk("R3", "unblocked irq pass", int'(irqOut), 1);
    chk("R3", "unblocked irq not held", int'(irqHeld), 0);
    @(negedge clk);
    chk("R3", "unblocked irq one cycle", int'(irqOut), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule